// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripheral sources and from external request pins and turns them into two processor request lines. One is a fast request, fed by a single dedicated pin and nothing else. The other is a normal request, fed by every other source. Each normal source has its own enable bit, its own trigger setting and a priority from 0 to 7. An eight-level resolver picks the winning source and serves the handler address programmed for it.

Software reads the vector register to fetch the handler address. That read also acknowledges the winner: the winner's priority becomes the new running level and is pushed onto an internal stack that holds up to eight levels. While that level runs, only a source with a strictly higher priority raises the normal request again, so handlers can nest. A write to the end-of-interrupt register pops the stack and restores the level that was running before.

Source numbering: the internal sources take indices 0 to N_INT-1, and the external lines take N_INT+j. The register port is a single-cycle strobe interface with 6-bit addresses. Read data is combinational, and a strobe takes effect at the clock edge that samples it.

Top module: `nest_irq_ctrl`

## Requirements
- R1: `fast_req` equals the value `fiq_in` had at the previous clock edge. No mask, configuration, source input or stack state affects it, and `fiq_in` never affects `irq_req`.
- R2: `irq_req` is registered. It is 1 one cycle after a state in which some enabled, pending source has a priority above the running level. When the stack is empty, any enabled pending source qualifies.
- R3: Enable bits are set by writing ones to address 0x00 and cleared by writing ones to address 0x01. Bit i controls source i. Reading 0x00 returns the enable bits. After reset every source is disabled. A disabled source neither raises `irq_req` nor wins arbitration.
- R4: Each source has a configuration word at address 0x10+i: bits [2:0] hold the priority and bits [4:3] hold the trigger mode. For an internal source, bit 4 = 1 selects rising-edge trigger and bit 4 = 0 selects high level. Bit 3 is ignored for internal sources.
- R5: For an external source, the trigger mode in bits [4:3] is 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge.
- R6: The pending, enabled source with the highest priority value wins. Among sources of equal priority, the lowest source index wins.
- R7: The handler address of source i is written at address 0x20+i. A read of address 0x03 returns the winner's handler address when `irq_req` would be set by the current state. Otherwise it returns 0.
- R8: A non-zero-result vector read acknowledges the winner. It clears the winner's edge latch and pushes the winner's priority as the new running level. Afterwards only a strictly higher priority raises `irq_req`.
- R9: Any write to address 0x05 pops the running level and restores the previous one. A pop with an empty stack has no effect.
- R10: Edge latches capture edges even while their source is disabled. Address 0x02 reads the pending bit of every source, enabled or not. Writing ones to 0x04 clears the selected edge latches. A source in level mode holds no latched edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_src | input | N_INT | Internal peripheral request lines, synchronous to clk |
| ext_irq | input | N_EXT | External normal request lines, synchronous to clk |
| fiq_in | input | 1 | Dedicated fast interrupt input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the acknowledge side effect) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address and state |
| fast_req | output | 1 | Fast request to the processor |
| irq_req | output | 1 | Normal request to the processor |

## Verification
Two kinds of internal fault show up at the ports in different ways. A wrong running level or a bad stack entry appears as `irq_req` staying high after an acknowledge, or as a nested source of equal priority breaking through; either shows within two cycles of the acknowledge or the end-of-interrupt write. A wrong edge latch or a wrong resolver choice appears on the very next vector read, as the wrong handler address or a spurious zero, and on the pending readback at 0x02. A bench model built from the requirements follows every operation, so a divergence is seen at the first check after the operation that caused it.

// File: rtl/nic_pkg.sv
package nic_pkg;

   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_LOW  = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

   localparam int unsigned REG_AW = 6;

   localparam logic [REG_AW-1:0] A_EN_SET  = 6'h00;
   localparam logic [REG_AW-1:0] A_EN_CLR  = 6'h01;
   localparam logic [REG_AW-1:0] A_PENDING = 6'h02;
   localparam logic [REG_AW-1:0] A_VECTOR  = 6'h03;
   localparam logic [REG_AW-1:0] A_EDGECLR = 6'h04;
   localparam logic [REG_AW-1:0] A_EOI     = 6'h05;

   localparam logic [1:0] PG_CFG = 2'b01;
   localparam logic [1:0] PG_VEC = 2'b10;

endpackage

// File: rtl/nic_src_cond.sv
module nic_src_cond #(
   parameter bit IS_EXT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  nic_pkg::trig_e  mode,
   input  logic            clr,
   output logic            pend,
   output logic            edge_evt
);

   logic prev_q;
   logic latch_q;
   logic lvl_act;
   logic edge_det;
   logic is_edge;

   assign is_edge = mode[1];

   generate
      if (IS_EXT) begin : g_ext
         always_comb begin
            lvl_act  = raw ^ mode[0];
            edge_det = mode[0] ? (prev_q & ~raw) : (raw & ~prev_q);
         end
      end else begin : g_int
         always_comb begin
            lvl_act  = raw;
            edge_det = raw & ~prev_q;
         end
      end
   endgenerate

   assign edge_evt = is_edge & edge_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= raw;
         latch_q <= is_edge & (edge_evt | (latch_q & ~clr));
      end
   end

   assign pend = is_edge ? latch_q : lvl_act;

   assert_edge_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt |=> latch_q);

endmodule

// File: rtl/nic_resolver.sv
module nic_resolver #(
   parameter int unsigned N         = 8,
   parameter int unsigned PW        = 3,
   parameter int unsigned ARB_STYLE = 1,
   localparam int unsigned IDX_W    = (N > 1) ? $clog2(N) : 1,
   localparam int unsigned LEVELS   = 1 << PW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         elig,
   input  logic [N-1:0][PW-1:0] prio,
   output logic                 win_valid,
   output logic [IDX_W-1:0]     win_idx,
   output logic [PW-1:0]        win_prio,
   output logic [N-1:0]         grant
);

   if (ARB_STYLE > 1) begin : g_bad_style
      $error("nic_resolver: ARB_STYLE must be 0 (scan) or 1 (level-sliced)");
   end

   generate
      if (ARB_STYLE == 0) begin : g_scan
         always_comb begin
            win_valid = 1'b0;
            win_idx   = '0;
            win_prio  = '0;
            for (int i = 0; i < N; i++) begin
               if (elig[i] && (!win_valid || prio[i] > win_prio)) begin
                  win_valid = 1'b1;
                  win_idx   = IDX_W'(i);
                  win_prio  = prio[i];
               end
            end
         end
      end else begin : g_sliced
         logic [LEVELS-1:0] lvl_hit;
         always_comb begin
            for (int l = 0; l < LEVELS; l++) begin
               lvl_hit[l] = 1'b0;
               for (int i = 0; i < N; i++) begin
                  if (elig[i] && prio[i] == PW'(l)) lvl_hit[l] = 1'b1;
               end
            end
         end
         always_comb begin
            win_prio = '0;
            for (int l = 0; l < LEVELS; l++) begin
               if (lvl_hit[l]) win_prio = PW'(l);
            end
            win_idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (elig[i] && prio[i] == win_prio) win_idx = IDX_W'(i);
            end
            win_valid = |elig;
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < N; i++) grant[i] = win_valid && (win_idx == IDX_W'(i));
   end

   assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (grant & elig) != '0);

   for (genvar g = 0; g < N; g++) begin : g_chk
      assert_top_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         elig[g] |-> (win_valid && prio[g] <= win_prio));
   end

endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PW    = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [PW-1:0] push_val,
   input  logic          pop,
   output logic [PW-1:0] top,
   output logic          empty
);

   if (DEPTH < (1 << PW)) begin : g_bad_depth
      $error("nic_lvl_stack: DEPTH must cover every priority level");
   end

   logic [DEPTH-1:0][PW-1:0] mem_q;
   logic [CNT_W-1:0]         cnt_q;
   logic                     full;
   logic [PTR_W-1:0]         top_ptr;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign top_ptr = PTR_W'(cnt_q - CNT_W'(1));
   assign top     = empty ? '0 : mem_q[top_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
         cnt_q <= '0;
      end else if (push && !full) begin
         mem_q[PTR_W'(cnt_q)] <= push_val;
         cnt_q                <= cnt_q + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   assert_push_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top == $past(push_val) && !empty));

   assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned N_INT     = 6,
   parameter int unsigned N_EXT     = 2,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ARB_STYLE = 1,
   localparam int unsigned N_SRC    = N_INT + N_EXT,
   localparam int unsigned IDX_W    = $clog2(N_SRC),
   localparam int unsigned LEVELS   = 1 << PRIO_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_INT-1:0]            int_src,
   input  logic [N_EXT-1:0]            ext_irq,
   input  logic                        fiq_in,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [nic_pkg::REG_AW-1:0]  reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   output logic                        fast_req,
   output logic                        irq_req
);
   import nic_pkg::*;

   if (N_SRC < 2 || N_SRC > 16) begin : g_bad_count
      $error("nest_irq_ctrl: source count must be 2..16");
   end
   if (DATA_W < N_SRC || DATA_W < PRIO_W + 2) begin : g_bad_width
      $error("nest_irq_ctrl: DATA_W too narrow");
   end
   if (PRIO_W != 3) begin : g_bad_prio
      $error("nest_irq_ctrl: resolver is specified for eight levels");
   end

   localparam logic [4:0] N_SRC_L = 5'(N_SRC);

   logic [N_SRC-1:0]             raw;
   logic [N_SRC-1:0]             en_q;
   logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
   trig_e                        mode_q [N_SRC];
   logic [DATA_W-1:0]            vec_q  [N_SRC];
   logic                         fast_q;
   logic                         irq_q;

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] edge_evt;
   logic [N_SRC-1:0] clr;
   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] grant;
   logic             win_valid;
   logic [IDX_W-1:0] win_idx;
   logic [PRIO_W-1:0] win_prio;
   logic [PRIO_W-1:0] run_lvl;
   logic             stk_empty;
   logic             above;
   logic             ack;
   logic             eoi;

   logic             sel_ok;
   logic [IDX_W-1:0] sel;
   logic             wr_cfg;
   logic             wr_vec;
   logic             wr_eclr;

   assign raw     = {ext_irq, int_src};
   assign sel_ok  = ({1'b0, reg_addr[3:0]} < N_SRC_L);
   assign sel     = reg_addr[IDX_W-1:0];
   assign wr_cfg  = reg_wr && reg_addr[5:4] == PG_CFG && sel_ok;
   assign wr_vec  = reg_wr && reg_addr[5:4] == PG_VEC && sel_ok;
   assign wr_eclr = reg_wr && reg_addr == A_EDGECLR;
   assign eoi     = reg_wr && reg_addr == A_EOI;

   // Source conditioning: internal and external variants chosen per index
   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign clr[g] = (wr_eclr && reg_wdata[g]) || (ack && grant[g]);
      nic_src_cond #(
         .IS_EXT (g >= N_INT)
      ) i_cond (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (raw[g]),
         .mode     (mode_q[g]),
         .clr      (clr[g]),
         .pend     (pend[g]),
         .edge_evt (edge_evt[g])
      );
   end

   assign elig = pend & en_q;

   nic_resolver #(
      .N         (N_SRC),
      .PW        (PRIO_W),
      .ARB_STYLE (ARB_STYLE)
   ) i_resolver (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig      (elig),
      .prio      (prio_q),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio),
      .grant     (grant)
   );

   assign above = win_valid && (stk_empty || win_prio > run_lvl);
   assign ack   = reg_rd && reg_addr == A_VECTOR && above;

   nic_lvl_stack #(
      .DEPTH (LEVELS),
      .PW    (PRIO_W)
   ) i_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack),
      .push_val (win_prio),
      .pop      (eoi),
      .top      (run_lvl),
      .empty    (stk_empty)
   );

   // Configuration storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         prio_q <= '0;
         for (int i = 0; i < N_SRC; i++) begin
            mode_q[i] <= TRIG_HIGH;
            vec_q[i]  <= '0;
         end
      end else begin
         if (reg_wr && reg_addr == A_EN_SET) en_q <= en_q | reg_wdata[N_SRC-1:0];
         if (reg_wr && reg_addr == A_EN_CLR) en_q <= en_q & ~reg_wdata[N_SRC-1:0];
         for (int i = 0; i < N_SRC; i++) begin
            if (wr_cfg && sel == IDX_W'(i)) begin
               prio_q[i] <= reg_wdata[PRIO_W-1:0];
               mode_q[i] <= trig_e'(reg_wdata[PRIO_W+1:PRIO_W]);
            end
            if (wr_vec && sel == IDX_W'(i)) vec_q[i] <= reg_wdata;
         end
      end
   end

   // Request outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         fast_q <= fiq_in;
         irq_q  <= above;
      end
   end

   assign fast_req = fast_q;
   assign irq_req  = irq_q;

   // Read data
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr[5:4])
         2'b00: begin
            case (reg_addr)
               A_EN_SET:  reg_rdata = DATA_W'(en_q);
               A_PENDING: reg_rdata = DATA_W'(pend);
               A_VECTOR:  reg_rdata = above ? vec_q[win_idx] : '0;
               default:   reg_rdata = '0;
            endcase
         end
         PG_CFG: if (sel_ok) reg_rdata = DATA_W'({mode_q[sel], prio_q[sel]});
         PG_VEC: if (sel_ok) reg_rdata = vec_q[sel];
         default: reg_rdata = '0;
      endcase
   end

   assert_fast_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> fast_req == $past(fiq_in));

   assert_ack_pushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!stk_empty && run_lvl == $past(win_prio)));

   assert_ack_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (elig != '0));

endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
   localparam int NI = 6;
   localparam int NE = 2;
   localparam int NS = NI + NE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NI-1:0] int_src = '0;
   logic [NE-1:0] ext_irq = '0;
   logic        fiq_in = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fast_req;
   logic        irq_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // model state
   bit [NS-1:0] m_en;
   bit [2:0]    m_prio [NS];
   bit [1:0]    m_mode [NS];
   bit [31:0]   m_vec  [NS];
   bit [NS-1:0] m_latch;
   bit [NS-1:0] m_raw;
   bit          m_fiq;
   bit [2:0]    m_stk [8];
   int          m_cnt;

   always #2 clk = ~clk;

   nest_irq_ctrl i_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_irq(ext_irq), .fiq_in(fiq_in),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fast_req(fast_req), .irq_req(irq_req));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit m_pend(input int i);
      if (m_mode[i][1]) return m_latch[i];
      if (i < NI) return m_raw[i];
      return m_raw[i] ^ m_mode[i][0];
   endfunction

   function automatic bit [NS-1:0] m_pend_vec();
      bit [NS-1:0] v;
      for (int i = 0; i < NS; i++) v[i] = m_pend(i);
      return v;
   endfunction

   function automatic int m_win();
      int b = -1;
      for (int i = 0; i < NS; i++)
         if (m_en[i] && m_pend(i) && (b < 0 || m_prio[i] > m_prio[b])) b = i;
      return b;
   endfunction

   function automatic bit m_above();
      int w = m_win();
      if (w < 0) return 1'b0;
      return (m_cnt == 0) || (m_prio[w] > m_stk[m_cnt-1]);
   endfunction

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic op_en(input bit [NS-1:0] v);  wr(6'h00, 32'(v)); m_en |= v;  endtask
   task automatic op_dis(input bit [NS-1:0] v); wr(6'h01, 32'(v)); m_en &= ~v; endtask
   task automatic op_eclr(input bit [NS-1:0] v); wr(6'h04, 32'(v)); m_latch &= ~v; endtask
   task automatic op_eoi(); wr(6'h05, 32'h5A); if (m_cnt > 0) m_cnt--; endtask

   task automatic op_cfg(input int i, input bit [1:0] mode, input bit [2:0] p);
      wr(6'h10 + 6'(i), {27'd0, mode, p});
      m_mode[i] = mode; m_prio[i] = p;
      if (!mode[1]) m_latch[i] = 1'b0;
   endtask

   task automatic op_vec(input int i, input bit [31:0] v);
      wr(6'h20 + 6'(i), v); m_vec[i] = v;
   endtask

   task automatic op_ack(input string tag, output logic [31:0] d);
      int w = m_win();
      bit a = m_above();
      rd(6'h03, d);
      chk(tag, d, a ? m_vec[w] : 32'h0);
      if (a) begin
         if (m_mode[w][1]) m_latch[w] = 1'b0;
         m_stk[m_cnt] = m_prio[w];
         m_cnt++;
      end
   endtask

   task automatic op_src(input bit [NS-1:0] nr, input bit nf);
      for (int i = 0; i < NS; i++) begin
         if (m_mode[i][1]) begin
            if (i < NI || m_mode[i][0] == 1'b0) begin
               if (!m_raw[i] && nr[i]) m_latch[i] = 1'b1;
            end else begin
               if (m_raw[i] && !nr[i]) m_latch[i] = 1'b1;
            end
         end
      end
      @(negedge clk);
      int_src = nr[NI-1:0]; ext_irq = nr[NS-1:NI]; fiq_in = nf;
      m_raw = nr; m_fiq = nf;
   endtask

   task automatic settle(input string tag);
      repeat (2) @(negedge clk);
      chk({tag, " irq_req"}, 32'(irq_req), 32'(m_above()));
      chk("R1 fast_req", 32'(fast_req), 32'(m_fiq));
   endtask

   task automatic chk_pend(input string tag);
      logic [31:0] d;
      rd(6'h02, d);
      chk(tag, d, 32'(m_pend_vec()));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1357));
      m_en = '0; m_latch = '0; m_raw = '0; m_fiq = 1'b0; m_cnt = 0;
      for (int i = 0; i < NS; i++) begin m_prio[i] = '0; m_mode[i] = '0; m_vec[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R3, R7, R2, R1)
      chk("R2 reset irq_req", 32'(irq_req), 32'h0);
      chk("R1 reset fast_req", 32'(fast_req), 32'h0);
      rd(6'h00, d); chk("R3 reset enables", d, 32'h0);
      rd(6'h03, d); chk("R7 reset spurious vector", d, 32'h0);

      for (int i = 0; i < NS; i++) op_vec(i, 32'h0000_1000 + 32'(i) * 32'h40);
      rd(6'h22, d); chk("R7 vector readback", d, 32'h0000_1080);

      // R1: fast path alone, everything disabled
      op_src('0, 1'b1); settle("R1");
      chk("R1 fast asserted", 32'(fast_req), 32'h1);
      chk("R1 no normal request", 32'(irq_req), 32'h0);
      op_src('0, 1'b0); settle("R1");

      // R3: disabled level source does not request
      op_cfg(0, 2'b00, 3'd2);
      op_src(8'h01, 1'b0); settle("R3");
      chk("R3 disabled silent", 32'(irq_req), 32'h0);
      op_en(8'h01); settle("R2");
      chk("R2 enabled level requests", 32'(irq_req), 32'h1);
      rd(6'h00, d); chk("R3 enable readback", d, 32'h01);
      op_dis(8'h01); settle("R3");
      op_en(8'h01);

      // R4: internal, bit 3 ignored
      op_cfg(1, 2'b01, 3'd5);
      chk_pend("R4 internal low-level bit ignored");
      op_src(8'h03, 1'b0); chk_pend("R4 internal high level");
      op_cfg(1, 2'b11, 3'd5);
      op_src(8'h01, 1'b0); chk_pend("R4 internal no fall trigger");
      op_src(8'h03, 1'b0); chk_pend("R4 internal rising latch");
      op_eclr(8'h02); chk_pend("R10 edge clear");

      // R5: external modes on source 6
      op_cfg(6, 2'b01, 3'd1); chk_pend("R5 ext low level");
      op_cfg(6, 2'b00, 3'd1); op_src(8'h43, 1'b0); chk_pend("R5 ext high level");
      op_cfg(6, 2'b11, 3'd1); op_src(8'h03, 1'b0); chk_pend("R5 ext falling");
      op_cfg(6, 2'b10, 3'd1); op_src(8'h43, 1'b0); chk_pend("R5 ext rising");
      op_src(8'h03, 1'b0); chk_pend("R5 ext rising no fall");
      // R10: masked source still latches
      chk("R10 masked latch", 32'(m_latch[6]), 32'h1);
      op_eclr(8'h40);

      // R6/R8 nesting
      op_cfg(1, 2'b00, 3'd5); op_cfg(2, 2'b00, 3'd5); op_cfg(4, 2'b10, 3'd7);
      op_en(8'h17);
      op_src(8'h07, 1'b0); settle("R6");
      op_ack("R6 tie lowest index", d); chk("R6 tie winner", d, 32'h0000_1040);
      settle("R8");
      chk("R8 equal level blocked", 32'(irq_req), 32'h0);
      op_src(8'h17, 1'b0); settle("R8");
      chk("R8 higher preempts", 32'(irq_req), 32'h1);
      op_ack("R8 nested vector", d); chk("R8 nested winner", d, 32'h0000_1100);
      chk_pend("R8 edge cleared by ack");
      op_ack("R7 spurious while nested", d); chk("R7 spurious zero", d, 32'h0);
      op_eoi(); settle("R9");
      op_eoi(); settle("R9");
      chk("R9 level restored", 32'(irq_req), 32'h1);
      op_eoi(); op_eoi(); settle("R9 pop empty");

      // constrained random
      for (int n = 0; n < 400; n++) begin
         int op = int'($urandom_range(0, 9));
         case (op)
            0, 1, 2: op_src(m_raw ^ NS'($urandom & $urandom), 1'($urandom));
            3, 4:    op_ack("R7 random vector", d);
            5:       op_eoi();
            6:       op_en(NS'($urandom));
            7:       op_dis(NS'($urandom & $urandom));
            8:       op_cfg(int'($urandom_range(0, NS-1)), 2'($urandom), 3'($urandom));
            default: op_eclr(NS'($urandom));
         endcase
         settle("R2 random");
         if (n % 8 == 0) chk_pend("R10 random pending");
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule